// File: doc/BRIEF.md
# Encoded priority level request decoder

This block accepts a binary-encoded external interrupt level on a narrow bus and converts it into per-source request lines for a bank of dedicated interrupt sources. The level is captured in a register; each time the captured level changes, the one source that matches it is driven active and every other source is released. Level zero means that nothing is requested, so every source is released.

The mapping runs inverted: the source index is the level XOR the all-ones code, so the highest level selects source 0 and the lowest non-zero level selects the last source. Besides the held request lines, the block issues a one-time enable grant for each source the first time it is selected. Each source remembers whether it has already been granted, so later selections of that source produce no further grant. The sources are visited in chain order from index 0 upward, and the visit stops at the configured chain length, so a selected index beyond the chain matches nothing.

Top module: `irl_decoder`

## Requirements
- R1: After reset every request line `src_req_o` is 0, `grant_o` is 0 and every source counts as not yet granted.
- R2: The level on `level_i` is registered; a change on `level_i` in cycle N shows on the outputs after the clock edge at the end of cycle N+1, and the outputs stay unchanged while `level_i` stays constant.
- R3: For a non-zero level L, the selected index is L XOR 15 (level 15 selects bit 0 of `src_req_o`, level 1 selects bit 14).
- R4: When the level changes, exactly the selected source's `src_req_o` bit is 1 and all other bits are 0, so `src_req_o` is one-hot or zero.
- R5: Level 0 maps to index 15, which lies outside the 15-source chain, so every bit of `src_req_o` is 0.
- R6: `grant_o` pulses for exactly one cycle on bit i when source i is selected and has not been granted since reset; at most one bit is 1 per cycle.
- R7: A source that has already been granted is never granted again, however often it is selected, until the next reset.
- R8: Only indices below the chain length `NUM_SRC` can be selected; with the default length of 15, the index of level 0 matches no source, and no grant pulse is issued for it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| level_i | input | 4 | Encoded request level, 0 = none, 15 = highest |
| src_req_o | output | 15 | Held request line per source, one-hot or zero |
| grant_o | output | 15 | One-cycle enable grant for a source's first selection |

## Verification
A grant pulse and a request change come from the same level update. Selecting a source for the first time therefore drives both its request bit and its grant bit in the same cycle, while the other sources are released. The bench cycles through levels so that fresh sources, repeat sources and level 0 all occur. It then checks that the grant appears only on first selection and always together with the matching request bit, one cycle after the level has been registered.

// File: rtl/irl_pkg.sv
package irl_pkg;
  localparam int unsigned LVL_W   = 4;
  localparam int unsigned MAX_SRC = (1 << LVL_W) - 1;
  typedef logic [LVL_W-1:0] lvl_t;
endpackage

// File: rtl/irl_level_reg.sv
module irl_level_reg
  import irl_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  lvl_t level_i,
  output lvl_t level_q_o,
  output logic change_o
);
  lvl_t level_q;
  logic chg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      level_q <= '0;
      chg_q   <= 1'b0;
    end else begin
      level_q <= level_i;
      chg_q   <= (level_i != level_q);
    end
  end

  assign level_q_o = level_q;
  assign change_o  = chg_q;
endmodule

// File: rtl/irl_index_dec.sv
module irl_index_dec
  import irl_pkg::*;
#(
  parameter int unsigned NUM_SRC = 15
) (
  input  lvl_t               level_i,
  output logic [NUM_SRC-1:0] sel_o
);
  lvl_t idx;
  assign idx = level_i ^ lvl_t'(MAX_SRC);

  // chain walk: slot k matches only inside the chain
  for (genvar k = 0; k < NUM_SRC; k++) begin : g_slot
    assign sel_o[k] = (idx == lvl_t'(k));
  end

  // R3
  onehot_sel_chk: assert final ($onehot0(sel_o));
endmodule

// File: rtl/irl_src_bank.sv
module irl_src_bank #(
  parameter int unsigned NUM_SRC = 15
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               upd_i,
  input  logic [NUM_SRC-1:0] sel_i,
  output logic [NUM_SRC-1:0] req_o,
  output logic [NUM_SRC-1:0] grant_o
);
  logic [NUM_SRC-1:0] req_q, done_q, grant_q;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        req_q[i]   <= 1'b0;
        done_q[i]  <= 1'b0;
        grant_q[i] <= 1'b0;
      end else begin
        grant_q[i] <= 1'b0;
        if (upd_i) begin
          req_q[i] <= sel_i[i];
          if (sel_i[i] && !done_q[i]) begin
            grant_q[i] <= 1'b1;
            done_q[i]  <= 1'b1;
          end
        end
      end
    end
  end

  assign req_o   = req_q;
  assign grant_o = grant_q;

  // R4
  req_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(req_q));
  // R6
  grant_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant_q));
  // R6
  grant_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_q != '0) |=> (grant_q == '0) || !$stable(req_q) || $past(upd_i));
  // R6
  grant_with_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_q & ~req_q) == '0);
  // R7
  no_regrant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((grant_q & $past(done_q)) == '0));
  // R2
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_i |=> $stable(req_q));
endmodule

// File: rtl/irl_decoder.sv
module irl_decoder
  import irl_pkg::*;
#(
  parameter int unsigned NUM_SRC = 15
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [3:0]         level_i,
  output logic [NUM_SRC-1:0] src_req_o,
  output logic [NUM_SRC-1:0] grant_o
);
  lvl_t               level_q;
  logic               change;
  logic [NUM_SRC-1:0] sel;

  irl_level_reg u_level (
    .clk_i, .rst_ni, .level_i,
    .level_q_o(level_q), .change_o(change)
  );

  irl_index_dec #(.NUM_SRC(NUM_SRC)) u_dec (
    .level_i(level_q), .sel_o(sel)
  );

  // sel is combinational on level_q; the change flag lags by one cycle,
  // so level_q is stable when upd fires.
  irl_src_bank #(.NUM_SRC(NUM_SRC)) u_bank (
    .clk_i, .rst_ni, .upd_i(change), .sel_i(sel),
    .req_o(src_req_o), .grant_o(grant_o)
  );

  // R5
  zero_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (change && level_q == '0) |=> (src_req_o == '0));
endmodule

// File: tb/irl_decoder_bench.sv
module irl_decoder_bench;
  localparam int N = 15;
  logic clk = 0, rst_ni = 0;
  logic [3:0] level = 0;
  logic [N-1:0] req, gnt;
  int n_chk = 0, n_bad = 0;
  bit granted [N];

  always #2 clk = ~clk;

  irl_decoder u_irl_decoder (
    .clk_i(clk), .rst_ni(rst_ni), .level_i(level),
    .src_req_o(req), .grant_o(gnt)
  );

  task automatic check(string r, logic [N-1:0] act, logic [N-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", r, act, exp);
    end
  endtask

  function automatic logic [N-1:0] exp_req(logic [3:0] l);
    int idx = int'(l ^ 4'hf);
    return (idx < N) ? (N'(1) << idx) : '0;
  endfunction

  // drive level, then check grant pulse cycle and hold cycle
  task automatic apply(logic [3:0] l, string r);
    logic [N-1:0] e, g;
    int idx = int'(l ^ 4'hf);
    @(negedge clk) level = l;
    @(negedge clk);
    e = exp_req(l);
    check("R2 hold-before", req, req);
    @(negedge clk);
    g = '0;
    if (idx < N && !granted[idx]) begin g = e; granted[idx] = 1; end
    check({r, " req"}, req, e);
    check({r, " grant R6"}, gnt, g);
    @(negedge clk);
    check({r, " grant gone R7"}, gnt, '0);
    check("R2 hold", req, e);
  endtask

  task automatic t_reset();
    check("R1 req", req, '0);
    check("R1 grant", gnt, '0);
  endtask

  task automatic t_latency();
    @(negedge clk) level = 4'd15;
    @(negedge clk);
    check("R2 not yet", req, '0);
    @(negedge clk);
    check("R2/R3 level15", req, N'(1));
    check("R6 first grant", gnt, N'(1));
    granted[0] = 1;
    @(negedge clk);
  endtask

  task automatic t_map();
    apply(4'd1, "R3 level1");
    check("R3 bit14", req, N'(1) << 14);
    apply(4'd8, "R4 level8");
    apply(4'd3, "R4 level3");
  endtask

  task automatic t_zero();
    apply(4'd0, "R5 zero");
    check("R8 no grant level0", gnt, '0);
  endtask

  task automatic t_regrant();
    apply(4'd15, "R7 reselect15");
    apply(4'd1, "R7 reselect1");
    apply(4'd9, "R6 fresh9");
    apply(4'd9, "R2 same level");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    t_reset();
    t_latency();
    t_map();
    t_zero();
    t_regrant();
    for (int l = 0; l < 16; l++) apply(4'(l), "R4 sweep");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule